// File: doc/BRIEF.md
# Banked Register Access Decoder

This block sits between a host bus and a set of 16-byte register windows, one window per bank. It accepts accesses 8, 16 or 32 bits wide, with four active-low byte enables marking the valid data lanes. The low address bits select a 16-bit word inside the window. Each enabled lane is mapped to a byte offset. A write becomes one strobe per written byte register of the current bank. A read collects the addressed bytes onto the lanes that asked for them.

A bank number is held in a bank select byte at offset 0xE of every window, so software can always switch banks without knowing the current one. The high byte of that word, at 0xF, is a fixed identification constant. The bank select shares a dword with offsets 0xC and 0xD. A full-width write aimed at that dword changes only the bank select, so a 32-bit host can switch banks without disturbing its neighbours. The first few bytes of each bank are internal scratch storage. The other register bytes are read from a flat input vector that the surrounding logic supplies.

Top module: `banked_reg_decoder`

## Requirements
- R1: After reset the current bank is 0. Offset 0xE reads as {SEL_FILL[7:2], bank}, which is 8'h30 in bank 0. Offset 0xF always reads ID_BYTE (8'h33).
- R2: With addr_i[1]=0, lane k (bits 8k+7..8k) maps to byte offset {addr_i[3:2], k}. With addr_i[1]=1, lane 0 maps to {addr_i[3:2],1,0}, lane 1 maps to {addr_i[3:2],1,1}, and lanes 2 and 3 take no part. A lane takes part only when its be_ni bit is 0.
- R3: rdata_o drives zero on every lane that does not take part, and is all zero when rd_i is low or the access misses.
- R4: An access hits only when aen_ni is 0 and addr_i[ADDR_W-1:4] equals BASE_ADDR[ADDR_W-1:4]. A miss raises no strobe and changes no state.
- R5: A hit write raises, in the same cycle, reg_wr_o bit bank*16+offset for each written offset from 0x0 to 0xD of the current bank only. The byte for offset o is presented on reg_wdata_o[8o+7:8o].
- R6: A hit write reaching offset 0xE loads bits [1:0] of that byte as the bank, which holds from the next access on. Writes to 0xF have no effect.
- R7: A hit write with be_ni=4'b0000 and addr_i[3:1]=3'b110 updates only the bank select: no strobe for offsets 0xC or 0xD. A narrower write to 0xC or 0xD strobes normally.
- R8: Offsets 0 to SCR_BYTES-1 of each bank are internal scratch bytes that reset to zero and read back what was last written in that bank. Offsets SCR_BYTES to 0xD read ext_rdata_i[(bank*16+o)*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| aen_ni | input | 1 | Active-low access qualifier |
| addr_i | input | ADDR_W-1 | Byte address bits ADDR_W-1..1 |
| be_ni | input | 4 | Active-low byte lane enables |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data, lane aligned |
| ext_rdata_i | input | NBANK*128 | External register bytes, by bank and offset |
| rdata_o | output | 32 | Read data, lane aligned |
| reg_wr_o | output | NBANK*16 | Per-register byte write strobes |
| reg_wdata_o | output | 128 | Write bytes arranged by window offset |

## Verification
The bench uses the default parameters: a 16-bit address, base 0x300, four banks and four scratch bytes per bank. With these values every bank has both a stored scratch region and an externally supplied region. Bank numbers from 0 to 3 all appear in the bank select byte, and offsets 0xC and 0xD are plain external registers, so a wrongly applied top-dword guard shows up on their strobes. Addresses just outside the base window and a raised qualifier are mixed into the random traffic.

// File: rtl/banked_reg_decoder.sv
module banked_reg_decoder #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0300,
  parameter int                NBANK     = 4,
  parameter int                SCR_BYTES = 4,
  parameter logic [7:0]        SEL_FILL  = 8'h30,
  parameter logic [7:0]        ID_BYTE   = 8'h33
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    aen_ni,
  input  logic [ADDR_W-1:1]       addr_i,
  input  logic [3:0]              be_ni,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [31:0]             wdata_i,
  input  logic [NBANK*16*8-1:0]   ext_rdata_i,
  output logic [31:0]             rdata_o,
  output logic [NBANK*16-1:0]     reg_wr_o,
  output logic [16*8-1:0]         reg_wdata_o
);
  localparam int WIN    = 16;
  localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int SEL_O  = WIN - 2;
  localparam int LAST_R = WIN - 3;

  function automatic logic [NBANK*WIN-1:0] top_mask();
    logic [NBANK*WIN-1:0] m = '0;
    for (int b = 0; b < NBANK; b++) begin
      m[b*WIN+12] = 1'b1;
      m[b*WIN+13] = 1'b1;
    end
    return m;
  endfunction

  logic [BW-1:0] bank_q;
  logic [7:0]    scr_q [NBANK][SCR_BYTES];

  logic          hit, do_wr, full_top;
  logic [1:0]    dw;
  logic          hw;
  logic [3:0]    lane_on;
  logic [3:0]    lane_off [4];
  logic [WIN-1:0] wsel;
  logic [WIN*8-1:0] wbyte, rbytes;

  assign hit      = !aen_ni && (addr_i[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign do_wr    = hit && wr_i;
  assign dw       = addr_i[3:2];
  assign hw       = addr_i[1];
  assign full_top = (be_ni == 4'b0000) && !hw && (dw == 2'd3);

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [1:0] kk;
      kk = 2'(k);
      lane_on[k]  = !be_ni[k] && (!hw || k < 2);
      lane_off[k] = hw ? {dw, 1'b1, kk[0]} : {dw, kk};
    end
  end

  always_comb begin
    wsel  = '0;
    wbyte = '0;
    for (int k = 0; k < 4; k++) begin
      if (lane_on[k]) begin
        wsel[lane_off[k]] = 1'b1;
        wbyte[{lane_off[k], 3'b000} +: 8] = wdata_i[k*8 +: 8];
      end
    end
    if (full_top) begin
      wsel[12] = 1'b0;
      wsel[13] = 1'b0;
    end
  end

  assign reg_wdata_o = wbyte;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar o = 0; o < WIN; o++) begin : g_off
      if (o <= LAST_R) begin : g_reg
        assign reg_wr_o[b*WIN+o] = do_wr && wsel[o] && (bank_q == BW'(b));
      end else begin : g_none
        assign reg_wr_o[b*WIN+o] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
    end else if (do_wr && wsel[SEL_O]) begin
      bank_q <= wbyte[SEL_O*8 +: BW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBANK; b++)
        for (int o = 0; o < SCR_BYTES; o++)
          scr_q[b][o] <= 8'h00;
    end else if (do_wr) begin
      for (int o = 0; o < SCR_BYTES; o++)
        if (wsel[o]) scr_q[bank_q][o] <= wbyte[o*8 +: 8];
    end
  end

  always_comb begin
    rbytes = '0;
    for (int o = SCR_BYTES; o <= LAST_R; o++)
      rbytes[o*8 +: 8] = ext_rdata_i[(int'(bank_q)*WIN + o)*8 +: 8];
    for (int o = 0; o < SCR_BYTES; o++)
      rbytes[o*8 +: 8] = scr_q[bank_q][o];
    rbytes[SEL_O*8 +: 8]     = {SEL_FILL[7:BW], bank_q};
    rbytes[(WIN-1)*8 +: 8]   = ID_BYTE;
  end

  always_comb begin
    for (int k = 0; k < 4; k++)
      rdata_o[k*8 +: 8] = (rd_i && hit && lane_on[k]) ? rbytes[{lane_off[k], 3'b000} +: 8] : 8'h00;
  end

  AST_MISS_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aen_ni || !wr_i) |-> (reg_wr_o == '0)); // R4
  AST_TOP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_ni == 4'b0000 && addr_i[3:1] == 3'b110) |-> ((reg_wr_o & top_mask()) == '0)); // R7
  AST_BANK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_i && !be_ni[2] && addr_i[3:1] == 3'b110) |=> (bank_q == $past(wdata_i[16 +: BW]))); // R6
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || aen_ni) |-> (rdata_o == 32'h0)); // R3
  AST_STROBE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(reg_wr_o) <= 4); // R5
endmodule

// File: tb/banked_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module banked_reg_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic aen_n = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [15:1] addr = '0;
  logic [3:0] be_n = 4'hF;
  logic [31:0] wdata = '0;
  logic [4*128-1:0] ext;
  logic [31:0] rdata;
  logic [63:0] strb;
  logic [127:0] wbytes;

  int errors = 0, checks = 0;
  int bank_m = 0;
  logic [7:0] scr_m [4][4];

  always #2.5 clk = ~clk;

  banked_reg_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .aen_ni(aen_n), .addr_i(addr), .be_ni(be_n),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .ext_rdata_i(ext),
    .rdata_o(rdata), .reg_wr_o(strb), .reg_wdata_o(wbytes));

  function automatic logic [7:0] ext_val(int b, int o);
    return 8'(b*37 + o*11 + 5);
  endfunction

  function automatic bit lane_used(logic [15:1] a, logic [3:0] be, int k);
    return !be[k] && (!a[1] || k < 2);
  endfunction

  function automatic int lane_offset(logic [15:1] a, int k);
    return a[1] ? (int'(a[3:2])*4 + 2 + (k % 2)) : (int'(a[3:2])*4 + k);
  endfunction

  function automatic bit is_hit(logic [15:1] a, logic an);
    return !an && (a[15:4] == 12'h030);
  endfunction

  function automatic logic [7:0] exp_byte(int o);
    if (o < 4) return scr_m[bank_m][o];
    if (o <= 13) return ext_val(bank_m, o);
    if (o == 14) return 8'h30 | 8'(bank_m);
    return 8'h33;
  endfunction

  function automatic bit guarded(logic [15:1] a, logic [3:0] be, int o);
    return be == 4'b0000 && a[3:1] == 3'b110 && (o == 12 || o == 13);
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit w, bit r, logic [15:1] a, logic [3:0] be, logic [31:0] d,
                        logic an, string req);
    logic [31:0] er;
    logic [63:0] es;
    bit wok;
    @(negedge clk);
    wr = w; rd = r; addr = a; be_n = be; wdata = d; aen_n = an;
    #1;
    er = '0; es = '0; wok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (lane_used(a, be, k)) begin
        int o = lane_offset(a, k);
        if (r && is_hit(a, an)) er[k*8 +: 8] = exp_byte(o);
        if (w && is_hit(a, an) && o <= 13 && !guarded(a, be, o)) begin
          es[bank_m*16 + o] = 1'b1;
          if (wbytes[o*8 +: 8] !== d[k*8 +: 8]) wok = 1'b0;
        end
      end
    end
    check(rdata === er, req, 128'(rdata), 128'(er));
    check(strb === es && wok, req, 128'(strb), 128'(es));
    @(posedge clk);
    if (w && is_hit(a, an)) begin
      int nb = bank_m;
      for (int k = 0; k < 4; k++) begin
        if (lane_used(a, be, k)) begin
          int o = lane_offset(a, k);
          if (o < 4) scr_m[bank_m][o] = d[k*8 +: 8];
          if (o == 14) nb = int'(d[k*8 +: 2]);
        end
      end
      bank_m = nb;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 16; o++) ext[(b*16+o)*8 +: 8] = ext_val(b, o);
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 4; o++) scr_m[b][o] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R3 idle outputs, R1 reset bank
    access(0, 0, 15'h0180, 4'hF, 0, 0, "R3");
    access(0, 1, 15'h0187, 4'b1100, 0, 0, "R1");
    access(0, 1, 15'h0186, 4'b0000, 0, 0, "R2");
    // R8 scratch writes and byte reads
    access(1, 0, 15'h0180, 4'b0000, 32'hDEADBEEF, 0, "R8");
    for (int k = 0; k < 4; k++)
      access(0, 1, 15'h0180, ~(4'b1 << k), 0, 0, "R8");
    access(0, 1, 15'h0181, 4'b1100, 0, 0, "R2");
    access(0, 1, 15'h0181, 4'b0000, 0, 0, "R3");
    // R6 bank switch then immediate access
    access(1, 0, 15'h0187, 4'b1110, 32'h0000_0002, 0, "R6");
    access(0, 1, 15'h0180, 4'b0000, 0, 0, "R6");
    access(1, 0, 15'h0180, 4'b1100, 32'h0000_5A5A, 0, "R5");
    access(1, 0, 15'h0187, 4'b1110, 32'h0000_0000, 0, "R6");
    access(0, 1, 15'h0180, 4'b0000, 0, 0, "R8");
    // R6 writes to 0xF ignored
    access(1, 0, 15'h0186, 4'b0111, 32'hFF00_0000, 0, "R6");
    access(0, 1, 15'h0187, 4'b1100, 0, 0, "R6");
    // R7 full dword to top dword
    access(1, 0, 15'h0186, 4'b0000, 32'hAA01_BBCC, 0, "R7");
    access(0, 1, 15'h0186, 4'b0000, 0, 0, "R7");
    access(1, 0, 15'h0186, 4'b1100, 32'h0000_1234, 0, "R7");
    access(1, 0, 15'h0186, 4'b1011, 32'h0003_0000, 0, "R7");
    // R4 misses
    access(1, 0, 15'h0180, 4'b0000, 32'h1111_1111, 1, "R4");
    access(1, 0, 15'h0188, 4'b0000, 32'h2222_2222, 0, "R4");
    access(0, 1, 15'h0180, 4'b0000, 0, 1, "R4");
    access(0, 1, 15'h0180, 4'b0000, 0, 0, "R4");
    for (int i = 0; i < 400; i++) begin
      logic [15:1] a = 15'h0180 | 15'($urandom_range(0, 7));
      logic an = ($urandom_range(0, 9) == 0);
      bit w = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) a[4] = 1'b1;
      access(w, !w, a, 4'($urandom), $urandom, an, "R5");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule